// File: doc/BRIEF.md
# Vector Group Sub-Program-Counter Register

This block holds the 32-bit state register that a core uses while it executes a group of scalar opcodes under a shared vector context. The register does two jobs. It records how far decode of the group's leading fields has progressed, in four phases: scalar mode, header captured, length configuration loaded, and tables loaded. It also holds a pointer, counted in 16-bit parcels, that walks through the opcode area of the group. The main program counter stays fixed on the group for the whole time. This register is what advances.

The fetch and decode logic drives the block. It raises a strobe when it sees a valid group header, together with the header fields. It strobes again when the length configuration word and the tables have been read, and it reports each retired opcode with its length. Software reads the whole register through `state_o`. It can jump inside the group by writing the pointer in either immediate or register form. The block rejects a write with an illegal-instruction pulse when the group is not running or when the target lies outside the opcode area. On trap entry the register is parked in a saved copy and the live register clears. On trap return the saved copy comes back with the pointer intact, and the phase steps back one stage so that the tables are fetched again.

Top module: `vgrp_subpc`

## Requirements
- R1: After reset, and after any reset applied mid-run, `state_o` is zero and `in_blk_o`, `exit_o` and `illegal_o` are low.
- R2: A header strobe is taken only in the scalar phase (bits 31:30 = 0). It sets the phase to 1, clears the pointer (bits 4:0) and the configuration field (bits 20:5), and stores the length-present flag in bit 29, the length extension in bits 28:26, the predicate-table code in bits 25:24, the register-table code in bits 23:22 and the wide-format flag in bit 21. In any other phase the strobe changes nothing.
- R3: In phase 1 with the length-present flag set, the block waits for the configuration strobe, then writes its 16-bit word into bits 20:5 and moves to phase 2. With the flag clear it moves to phase 2 on the next clock by itself and leaves bits 20:5 at zero.
- R4: The tables-loaded strobe in phase 2 moves the block to phase 3. If the opcode area is empty, the register clears instead and `exit_o` pulses.
- R5: The opcode area length in parcels is 5 + ext_len - 1 - length_present - u(pred code) - u(reg code), floored at zero, where u maps codes 0,1,2,3 to 0,1,2,4.
- R6: In phase 3, a retire with a length of 1, 2 or 3 parcels adds that length to the pointer. A retire with a length of 0, or any retire outside phase 3, has no effect.
- R7: A retire that brings the pointer to or past the end of the opcode area clears the whole register to zero and raises `exit_o` for exactly one cycle.
- R8: An immediate-form write (the low 5 bits of `wr_data_i`) in phase 3 with a target below the area length replaces only the pointer. All other bits stay unchanged.
- R9: A register-form write compares the full 32-bit value with the area length. A target at or beyond the end, including a value whose low 5 bits would fit, leaves the register unchanged and pulses `illegal_o`.
- R10: A write in any phase other than 3 pulses `illegal_o` for one cycle and leaves the register unchanged.
- R11: Trap entry saves the register and clears the live copy. Trap return reloads the saved copy with the pointer kept, and a saved phase 3 comes back as phase 2.
- R12: When several inputs arrive in the same cycle, the priority is trap entry, then trap return, then write, then retire, then the phase strobes. An input that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Valid group header seen |
| hdr_vl_i | input | 1 | Header: length configuration word present |
| hdr_len_i | input | 3 | Header: length extension in 16-bit parcels |
| hdr_ptab_i | input | 2 | Header: predicate table size code |
| hdr_rtab_i | input | 2 | Header: register table size code |
| hdr_wide_i | input | 1 | Header: wide table format |
| cfg_done_i | input | 1 | Length configuration word read |
| cfg_data_i | input | 16 | Length configuration word |
| tab_done_i | input | 1 | Predicate and register tables loaded |
| ret_valid_i | input | 1 | Opcode retired inside the group |
| ret_units_i | input | 2 | Retired opcode length in parcels |
| wr_valid_i | input | 1 | Software write to the pointer |
| wr_imm_i | input | 1 | 1: immediate form, 0: register form |
| wr_data_i | input | 32 | Write value |
| trap_enter_i | input | 1 | Trap taken |
| trap_ret_i | input | 1 | Return from trap |
| state_o | output | 32 | Full register, also the software read value |
| in_blk_o | output | 1 | Phase is not scalar |
| exit_o | output | 1 | One-cycle pulse on leaving the group |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The bench probes the edges of the opcode area. It writes the last legal pointer and the first illegal one, and it sends a retire that lands exactly on the end and one that overshoots it. A design with an off-by-one comparison would accept a jump past the end or finish a group one opcode early. The bench also writes a register-form value whose low bits are in range but whose upper bits are not; a design that truncates that value would quietly jump. It covers a header with no length word, which must advance alone, and a header whose tables fill the whole group, which must exit as soon as the tables load. The final checks cover the trap round trip, which must keep the pointer while dropping back a phase, and inputs that collide in one cycle, where a wrong priority would move the pointer or raise a false illegal pulse.

// File: rtl/vgrp_subpc_pkg.sv
`timescale 1ns/1ps
package vgrp_subpc_pkg;

   localparam int REG_W  = 32;
   localparam int LEN_W  = 3;
   localparam int TAB_W  = 2;
   localparam int CFG_W  = 16;
   localparam int PTR_W  = 5;
   localparam int SPAN_W = PTR_W + 1;

   typedef enum logic [1:0] {
      PH_SCALAR = 2'd0,
      PH_HDR    = 2'd1,
      PH_CFG    = 2'd2,
      PH_RUN    = 2'd3
   } phase_e;

   typedef struct packed {
      phase_e             phase;
      logic               vl_on;
      logic [LEN_W-1:0]   ext_len;
      logic [TAB_W-1:0]   ptab;
      logic [TAB_W-1:0]   rtab;
      logic               wide;
      logic [CFG_W-1:0]   lencfg;
      logic [PTR_W-1:0]   ip;
   } sub_state_t;

   // parcels taken by a table of the given size code
   function automatic logic [SPAN_W-1:0] tab_units(input logic [TAB_W-1:0] code);
      logic [SPAN_W-1:0] r;
      r = SPAN_W'(code);
      if (code == {TAB_W{1'b1}}) r = SPAN_W'(1) << (TAB_W);
      return r;
   endfunction

endpackage

// File: rtl/vgrp_span_calc.sv
`timescale 1ns/1ps
module vgrp_span_calc
   import vgrp_subpc_pkg::*;
#(
   parameter int BASE_UNITS = 5,
   parameter int HDR_UNITS  = 1
) (
   input  sub_state_t         st_i,
   output logic [SPAN_W-1:0]  span_o
);

   logic [SPAN_W-1:0] total;
   logic [SPAN_W-1:0] used;

   always_comb begin
      total = SPAN_W'(BASE_UNITS) + SPAN_W'(st_i.ext_len);
      used  = SPAN_W'(HDR_UNITS) + SPAN_W'(st_i.vl_on)
            + tab_units(st_i.ptab) + tab_units(st_i.rtab);
      span_o = (total > used) ? (total - used) : '0;
   end

   // R5: the opcode area never exceeds the encoded group size
   always_comb begin
      if (!$isunknown(st_i)) begin
         AST_SPAN_BOUND: assert (span_o <= SPAN_W'(BASE_UNITS + (2**LEN_W) - 1 - HDR_UNITS)) // R5
            else $error("span beyond group size");
      end
   end

endmodule

// File: rtl/vgrp_trap_store.sv
`timescale 1ns/1ps
module vgrp_trap_store
   import vgrp_subpc_pkg::*;
#(
   parameter bit RESTORE_REFETCH = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        save_i,
   input  sub_state_t  live_i,
   output sub_state_t  rest_o
);

   sub_state_t held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_q <= '0;
      else if (save_i) held_q <= live_i;
   end

   generate
      if (RESTORE_REFETCH) begin : g_refetch
         always_comb begin
            rest_o = held_q;
            if (held_q.phase == PH_RUN) rest_o.phase = PH_CFG;
         end
      end else begin : g_direct
         always_comb rest_o = held_q;
      end
   endgenerate

endmodule

// File: rtl/vgrp_seq.sv
`timescale 1ns/1ps
module vgrp_seq
   import vgrp_subpc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hdr_valid_i,
   input  logic               hdr_vl_i,
   input  logic [LEN_W-1:0]   hdr_len_i,
   input  logic [TAB_W-1:0]   hdr_ptab_i,
   input  logic [TAB_W-1:0]   hdr_rtab_i,
   input  logic               hdr_wide_i,
   input  logic               cfg_done_i,
   input  logic [CFG_W-1:0]   cfg_data_i,
   input  logic               tab_done_i,
   input  logic               ret_valid_i,
   input  logic [1:0]         ret_units_i,
   input  logic               wr_valid_i,
   input  logic               wr_imm_i,
   input  logic [REG_W-1:0]   wr_data_i,
   input  logic               trap_enter_i,
   input  logic               trap_ret_i,
   input  sub_state_t         rest_i,
   input  logic [SPAN_W-1:0]  span_i,
   output sub_state_t         st_o,
   output logic               exit_o,
   output logic               illegal_o
);

   sub_state_t         st_q, st_n;
   logic               exit_n, ill_n;
   logic [REG_W-1:0]   wr_target;
   logic [SPAN_W-1:0]  advanced;

   always_comb begin
      wr_target = wr_imm_i ? REG_W'(wr_data_i[PTR_W-1:0]) : wr_data_i;
      advanced  = SPAN_W'(st_q.ip) + SPAN_W'(ret_units_i);
   end

   always_comb begin
      st_n   = st_q;
      exit_n = 1'b0;
      ill_n  = 1'b0;
      if (trap_enter_i) begin
         st_n = '0;
      end else if (trap_ret_i) begin
         st_n = rest_i;
      end else if (wr_valid_i) begin
         if (st_q.phase == PH_RUN && wr_target < REG_W'(span_i))
            st_n.ip = wr_target[PTR_W-1:0];
         else
            ill_n = 1'b1;
      end else begin
         unique case (st_q.phase)
            PH_SCALAR: if (hdr_valid_i) begin
               st_n.phase   = PH_HDR;
               st_n.vl_on   = hdr_vl_i;
               st_n.ext_len = hdr_len_i;
               st_n.ptab    = hdr_ptab_i;
               st_n.rtab    = hdr_rtab_i;
               st_n.wide    = hdr_wide_i;
               st_n.lencfg  = '0;
               st_n.ip      = '0;
            end
            PH_HDR: begin
               if (!st_q.vl_on) begin
                  st_n.phase = PH_CFG;
               end else if (cfg_done_i) begin
                  st_n.phase  = PH_CFG;
                  st_n.lencfg = cfg_data_i;
               end
            end
            PH_CFG: if (tab_done_i) begin
               if (span_i == '0) begin
                  st_n   = '0;
                  exit_n = 1'b1;
               end else begin
                  st_n.phase = PH_RUN;
               end
            end
            PH_RUN: if (ret_valid_i && ret_units_i != 2'd0) begin
               if (advanced >= span_i) begin
                  st_n   = '0;
                  exit_n = 1'b1;
               end else begin
                  st_n.ip = advanced[PTR_W-1:0];
               end
            end
            default: st_n = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= '0;
         exit_o    <= 1'b0;
         illegal_o <= 1'b0;
      end else begin
         st_q      <= st_n;
         exit_o    <= exit_n;
         illegal_o <= ill_n;
      end
   end

   assign st_o = st_q;

   AST_HDR_ONLY_FROM_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q.phase == PH_SCALAR && !hdr_valid_i && !trap_ret_i) |=> st_q.phase == PH_SCALAR) // R2
      else $error("left scalar phase without a header");

   AST_PTR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q.phase == PH_RUN) |-> (SPAN_W'(st_q.ip) < span_i)) // R6
      else $error("pointer outside opcode area");

   AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      exit_o |-> (st_q == '0)) // R7
      else $error("exit with live context");

   AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      exit_o |=> !exit_o) // R7
      else $error("exit pulse longer than one cycle");

   AST_WRITE_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && !trap_enter_i && !trap_ret_i && st_q.phase != PH_RUN) |=> illegal_o) // R10
      else $error("write outside run phase not flagged");

   AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && !trap_enter_i && !trap_ret_i && st_q.phase != PH_RUN) |=> $stable(st_q)) // R10
      else $error("rejected write changed state");

endmodule

// File: rtl/vgrp_subpc.sv
`timescale 1ns/1ps
module vgrp_subpc
   import vgrp_subpc_pkg::*;
#(
   parameter int BASE_UNITS      = 5,
   parameter int HDR_UNITS       = 1,
   parameter bit RESTORE_REFETCH = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hdr_valid_i,
   input  logic        hdr_vl_i,
   input  logic [2:0]  hdr_len_i,
   input  logic [1:0]  hdr_ptab_i,
   input  logic [1:0]  hdr_rtab_i,
   input  logic        hdr_wide_i,
   input  logic        cfg_done_i,
   input  logic [15:0] cfg_data_i,
   input  logic        tab_done_i,
   input  logic        ret_valid_i,
   input  logic [1:0]  ret_units_i,
   input  logic        wr_valid_i,
   input  logic        wr_imm_i,
   input  logic [31:0] wr_data_i,
   input  logic        trap_enter_i,
   input  logic        trap_ret_i,
   output logic [31:0] state_o,
   output logic        in_blk_o,
   output logic        exit_o,
   output logic        illegal_o
);

   localparam int MAX_SPAN = BASE_UNITS + (2**LEN_W) - 1 - HDR_UNITS;

   generate
      if ($bits(sub_state_t) != REG_W) begin : g_bad_layout
         $error("register layout must fill %0d bits", REG_W);
      end
      if (HDR_UNITS < 1 || BASE_UNITS <= HDR_UNITS) begin : g_bad_units
         $error("header must take at least one parcel and fit in the group");
      end
      if (MAX_SPAN > (2**PTR_W)) begin : g_bad_ptr
         $error("pointer too narrow for the largest opcode area");
      end
   endgenerate

   sub_state_t        live;
   sub_state_t        restored;
   logic [SPAN_W-1:0] span;

   vgrp_span_calc #(
      .BASE_UNITS (BASE_UNITS),
      .HDR_UNITS  (HDR_UNITS)
   ) i_span (
      .st_i   (live),
      .span_o (span)
   );

   vgrp_trap_store #(
      .RESTORE_REFETCH (RESTORE_REFETCH)
   ) i_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .save_i (trap_enter_i),
      .live_i (live),
      .rest_o (restored)
   );

   vgrp_seq i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .hdr_valid_i  (hdr_valid_i),
      .hdr_vl_i     (hdr_vl_i),
      .hdr_len_i    (hdr_len_i),
      .hdr_ptab_i   (hdr_ptab_i),
      .hdr_rtab_i   (hdr_rtab_i),
      .hdr_wide_i   (hdr_wide_i),
      .cfg_done_i   (cfg_done_i),
      .cfg_data_i   (cfg_data_i),
      .tab_done_i   (tab_done_i),
      .ret_valid_i  (ret_valid_i),
      .ret_units_i  (ret_units_i),
      .wr_valid_i   (wr_valid_i),
      .wr_imm_i     (wr_imm_i),
      .wr_data_i    (wr_data_i),
      .trap_enter_i (trap_enter_i),
      .trap_ret_i   (trap_ret_i),
      .rest_i       (restored),
      .span_i       (span),
      .st_o         (live),
      .exit_o       (exit_o),
      .illegal_o    (illegal_o)
   );

   assign state_o  = live;
   assign in_blk_o = (live.phase != PH_SCALAR);

   AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_enter_i |=> !in_blk_o) // R11
      else $error("trap entry left block active");

   generate
      if (RESTORE_REFETCH) begin : g_chk_refetch
         AST_RESTORE_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
            (trap_ret_i && !trap_enter_i) |=> (live.phase != PH_RUN)) // R11
            else $error("restore kept the run phase");
      end
   endgenerate

endmodule

// File: tb/test_vgrp_subpc.sv
`timescale 1ns/1ps
module test_vgrp_subpc;

   localparam logic [3:0] OP_IDLE = 4'd0, OP_HDR = 4'd1, OP_CFG = 4'd2, OP_TAB = 4'd3,
                          OP_RET  = 4'd4, OP_WIMM = 4'd5, OP_WREG = 4'd6, OP_TENT = 4'd7,
                          OP_TRET = 4'd8, OP_WRRET = 4'd9, OP_TENTWR = 4'd10;
   localparam int NV = 38;

   // {op, arg, expected state, expected exit, expected illegal}
   localparam logic [69:0] VEC [NV] = '{
      {OP_HDR,   32'h0000019F, 32'h7DA00000, 1'b0, 1'b0}, // R2 capture
      {OP_HDR,   32'h00000000, 32'h7DA00000, 1'b0, 1'b0}, // R2 ignored outside scalar
      {OP_IDLE,  32'h0,        32'h7DA00000, 1'b0, 1'b0}, // R3 waits for word
      {OP_CFG,   32'h0000BEEF, 32'hBDB7DDE0, 1'b0, 1'b0}, // R3 word stored
      {OP_RET,   32'h2,        32'hBDB7DDE0, 1'b0, 1'b0}, // R6 retire outside run
      {OP_WIMM,  32'h1,        32'hBDB7DDE0, 1'b0, 1'b1}, // R10
      {OP_TAB,   32'h0,        32'hFDB7DDE0, 1'b0, 1'b0}, // R4
      {OP_RET,   32'h2,        32'hFDB7DDE2, 1'b0, 1'b0}, // R6
      {OP_RET,   32'h0,        32'hFDB7DDE2, 1'b0, 1'b0}, // R6 zero length
      {OP_RET,   32'h3,        32'hFDB7DDE5, 1'b0, 1'b0}, // R6
      {OP_WIMM,  32'h6,        32'hFDB7DDE6, 1'b0, 1'b0}, // R8 R5 last legal
      {OP_WIMM,  32'h7,        32'hFDB7DDE6, 1'b0, 1'b1}, // R5 first illegal
      {OP_WREG,  32'h00000021, 32'hFDB7DDE6, 1'b0, 1'b1}, // R9 full width compared
      {OP_WREG,  32'h00000002, 32'hFDB7DDE2, 1'b0, 1'b0}, // R9
      {OP_TENT,  32'h0,        32'h00000000, 1'b0, 1'b0}, // R11 save
      {OP_RET,   32'h1,        32'h00000000, 1'b0, 1'b0}, // R6 ignored in scalar
      {OP_TRET,  32'h0,        32'hBDB7DDE2, 1'b0, 1'b0}, // R11 restore
      {OP_TAB,   32'h0,        32'hFDB7DDE2, 1'b0, 1'b0}, // R11 pointer kept
      {OP_RET,   32'h3,        32'hFDB7DDE5, 1'b0, 1'b0}, // R6
      {OP_RET,   32'h2,        32'h00000000, 1'b1, 1'b0}, // R7 exact end
      {OP_IDLE,  32'h0,        32'h00000000, 1'b0, 1'b0}, // R7 single pulse
      {OP_WREG,  32'h1,        32'h00000000, 1'b0, 1'b1}, // R10 scalar write
      {OP_HDR,   32'h000000C0, 32'h40C00000, 1'b0, 1'b0}, // R2
      {OP_IDLE,  32'h0,        32'h80C00000, 1'b0, 1'b0}, // R3 self-advance
      {OP_TAB,   32'h0,        32'h00000000, 1'b1, 1'b0}, // R4 empty area
      {OP_HDR,   32'h00000032, 32'h47000000, 1'b0, 1'b0}, // R5 one parcel
      {OP_IDLE,  32'h0,        32'h87000000, 1'b0, 1'b0}, // R3
      {OP_TAB,   32'h0,        32'hC7000000, 1'b0, 1'b0}, // R4
      {OP_WIMM,  32'h1,        32'hC7000000, 1'b0, 1'b1}, // R5
      {OP_WIMM,  32'h0,        32'hC7000000, 1'b0, 1'b0}, // R5
      {OP_RET,   32'h3,        32'h00000000, 1'b1, 1'b0}, // R7 overshoot
      {OP_HDR,   32'h0000000F, 32'h7C000000, 1'b0, 1'b0}, // R2
      {OP_CFG,   32'h00000001, 32'hBC000020, 1'b0, 1'b0}, // R3
      {OP_TAB,   32'h0,        32'hFC000020, 1'b0, 1'b0}, // R4
      {OP_WRRET, 32'h4,        32'hFC000024, 1'b0, 1'b0}, // R12 write beats retire
      {OP_TENTWR,32'h9,        32'h00000000, 1'b0, 1'b0}, // R12 trap beats write
      {OP_TRET,  32'h0,        32'hBC000024, 1'b0, 1'b0}, // R11
      {OP_TAB,   32'h0,        32'hFC000024, 1'b0, 1'b0}  // R11
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_valid_i = 1'b0, hdr_vl_i = 1'b0, hdr_wide_i = 1'b0;
   logic [2:0]  hdr_len_i = '0;
   logic [1:0]  hdr_ptab_i = '0, hdr_rtab_i = '0;
   logic        cfg_done_i = 1'b0, tab_done_i = 1'b0, ret_valid_i = 1'b0;
   logic [15:0] cfg_data_i = '0;
   logic [1:0]  ret_units_i = '0;
   logic        wr_valid_i = 1'b0, wr_imm_i = 1'b0;
   logic [31:0] wr_data_i = '0;
   logic        trap_enter_i = 1'b0, trap_ret_i = 1'b0;
   logic [31:0] state_o;
   logic        in_blk_o, exit_o, illegal_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   vgrp_subpc i_vgrp_subpc (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid_i(hdr_valid_i), .hdr_vl_i(hdr_vl_i), .hdr_len_i(hdr_len_i),
      .hdr_ptab_i(hdr_ptab_i), .hdr_rtab_i(hdr_rtab_i), .hdr_wide_i(hdr_wide_i),
      .cfg_done_i(cfg_done_i), .cfg_data_i(cfg_data_i), .tab_done_i(tab_done_i),
      .ret_valid_i(ret_valid_i), .ret_units_i(ret_units_i),
      .wr_valid_i(wr_valid_i), .wr_imm_i(wr_imm_i), .wr_data_i(wr_data_i),
      .trap_enter_i(trap_enter_i), .trap_ret_i(trap_ret_i),
      .state_o(state_o), .in_blk_o(in_blk_o), .exit_o(exit_o), .illegal_o(illegal_o)
   );

   task automatic clear_inputs();
      hdr_valid_i = 0; hdr_vl_i = 0; hdr_len_i = 0; hdr_ptab_i = 0; hdr_rtab_i = 0;
      hdr_wide_i = 0; cfg_done_i = 0; cfg_data_i = 0; tab_done_i = 0; ret_valid_i = 0;
      ret_units_i = 0; wr_valid_i = 0; wr_imm_i = 0; wr_data_i = 0;
      trap_enter_i = 0; trap_ret_i = 0;
   endtask

   task automatic compare(input string req, input logic [31:0] exp_st,
                          input logic exp_exit, input logic exp_ill);
      logic exp_in;
      exp_in = (exp_st[31:30] != 2'b00);
      checks++;
      if (state_o !== exp_st || exit_o !== exp_exit || illegal_o !== exp_ill || in_blk_o !== exp_in) begin
         fails++;
         $display("FAIL %s: state=%h exit=%b ill=%b in=%b, expected state=%h exit=%b ill=%b in=%b",
                  req, state_o, exit_o, illegal_o, in_blk_o, exp_st, exp_exit, exp_ill, exp_in);
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 compare("R1 reset state", 32'h0, 1'b0, 1'b0);
      @(negedge clk) rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         logic [3:0]  op;
         logic [31:0] arg;
         op  = VEC[k][69:66];
         arg = VEC[k][65:34];
         @(negedge clk);
         clear_inputs();
         case (op)
            OP_HDR: begin
               hdr_valid_i = 1; hdr_vl_i = arg[0]; hdr_len_i = arg[3:1];
               hdr_ptab_i = arg[5:4]; hdr_rtab_i = arg[7:6]; hdr_wide_i = arg[8];
            end
            OP_CFG:   begin cfg_done_i = 1; cfg_data_i = arg[15:0]; end
            OP_TAB:   tab_done_i = 1;
            OP_RET:   begin ret_valid_i = 1; ret_units_i = arg[1:0]; end
            OP_WIMM:  begin wr_valid_i = 1; wr_imm_i = 1; wr_data_i = arg; end
            OP_WREG:  begin wr_valid_i = 1; wr_imm_i = 0; wr_data_i = arg; end
            OP_TENT:  trap_enter_i = 1;
            OP_TRET:  trap_ret_i = 1;
            OP_WRRET: begin wr_valid_i = 1; wr_imm_i = 1; wr_data_i = arg;
                            ret_valid_i = 1; ret_units_i = 2'd1; end
            OP_TENTWR: begin trap_enter_i = 1; wr_valid_i = 1; wr_imm_i = 1; wr_data_i = arg; end
            default: ;
         endcase
         @(posedge clk);
         #1 compare($sformatf("vector %0d", k), VEC[k][33:2], VEC[k][1], VEC[k][0]);
      end

      // R1: reset mid-run clears everything
      @(negedge clk);
      clear_inputs();
      rst_n = 1'b0;
      #2 compare("R1 reset mid-run", 32'h0, 1'b0, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 compare("R1 after release", 32'h0, 1'b0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule